// File: doc/BRIEF.md
# Thread Block Admission and Warp Partitioner

This block sits in front of one multiprocessor and decides whether a block launch request may become resident. A request carries a thread count from 1 to 1024. It is admitted only when two limits both allow it: fewer than eight blocks are resident, and the resident thread total plus the new count stays within 1536. A request that does not fit is held with `req_ready` low. It is accepted unchanged once a retirement frees enough room, so requests never pass each other.

An admitted block takes the lowest-numbered free residency slot. It is then split into 32-lane warps. Warps are issued one per cycle, starting the cycle after acceptance, and each carries its slot, its warp number, its first and last thread id and an active-lane mask. Retiring a resident slot frees the slot and lowers both residency counters in the same cycle.

Top module: `block_admit_warp_split`

## Requirements
- R1: After reset, no block is resident, both counters read zero, `warp_valid` is low and `req_ready` is high.
- R2: A request is accepted (`req_valid` and `req_ready` high at a rising edge) only when the resident block count is below 8 and the resident thread count plus `req_threads` is at most 1536. Otherwise `req_ready` stays low and the request waits unchanged.
- R3: An accepted block is assigned the lowest-numbered free slot (0 to 7). Every warp of the block reports that slot on `warp_slot`.
- R4: A block of N threads yields ceil(N/32) warps. They appear on consecutive cycles starting one cycle after acceptance, with `warp_id` counting up from 0.
- R5: Warp k covers thread ids 32k to min(32k+31, N-1), reported on `warp_first_tid` and `warp_last_tid`.
- R6: Bit i of `warp_lane_mask` for warp k is 1 exactly when 32k+i < N. Full warps show all ones, and the last warp has its unused upper lanes cleared.
- R7: While a block's warps are being issued, `req_ready` is low.
- R8: Retiring a resident slot clears that slot. One cycle later, the block count has dropped by one and the thread count has dropped by that block's size.
- R9: Retiring a slot that holds no block changes neither counter nor any slot.
- R10: An acceptance and a retirement at the same edge are both applied. The block count is unchanged, and the thread count changes by the new size minus the retired size.
- R11: With 1024-thread blocks only one block is resident at a time. With 64-thread blocks the block limit stops admission at 8 blocks and 512 threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A block launch request is present |
| req_threads | input | 11 | Threads in the requested block, 1 to 1024 |
| req_ready | output | 1 | Request is accepted at this edge if valid |
| retire_valid | input | 1 | A block finished and leaves residency |
| retire_slot | input | 3 | Slot of the retiring block |
| warp_valid | output | 1 | A warp descriptor is presented this cycle |
| warp_slot | output | 3 | Slot of the block the warp belongs to |
| warp_id | output | 5 | Warp number within its block |
| warp_first_tid | output | 10 | First thread id covered by the warp |
| warp_last_tid | output | 10 | Last thread id covered by the warp |
| warp_lane_mask | output | 32 | Active lanes of the warp, bit 0 is the first thread |
| resident_blocks | output | 4 | Number of resident blocks |
| resident_threads | output | 11 | Total threads of the resident blocks |

## Verification
Block sizes of 1, 33, 40, 256, 64 and 1024 threads are launched. They separate exact multiples of 32 from partial last warps, single-lane warps and the largest split, so both the warp count and the mask edge are exposed. The thread limit is reached with six 256-thread blocks while slots remain free, and the block limit is reached with eight 64-thread blocks while thread room remains. Each hold is therefore attributed to one limit only. Retirements are applied to free slots, to a slot that frees room for a waiting request, and at the same edge as an acceptance, to show that the two counter updates combine and that the freed slot is reused as the lowest free one.

// File: rtl/adm_pkg.sv
// Package adm_pkg
// Shared helpers and types for the block admission and warp partitioner.
// Assumes: callers pass positive sizes to the width helper.
package adm_pkg;

    // State of the warp splitter: waiting for a block or issuing its warps.
    typedef enum logic {
        SPLIT_IDLE = 1'b0,
        SPLIT_RUN  = 1'b1
    } split_state_t;

    // Bits needed to index n items (at least one bit).
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/adm_capacity.sv
// Module adm_capacity
// Holds the resident block and thread counters and judges whether a request fits.
// Assumes: admit is only raised when fits is high; release_en only for a resident block.
module adm_capacity #(
    parameter int unsigned MAX_BLOCKS  = 8,
    parameter int unsigned MAX_THREADS = 1536,
    parameter int unsigned REQ_W       = 11,
    parameter int unsigned RES_W       = 11,
    parameter int unsigned CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REQ_W-1:0] req_threads,
    input  logic             admit,
    input  logic             release_en,
    input  logic [REQ_W-1:0] release_threads,
    output logic             fits,
    output logic [CNT_W-1:0] blk_cnt,
    output logic [RES_W-1:0] thr_cnt
);

    // Both limits are checked together against the current counts.
    always_comb begin
        fits = (int'(blk_cnt) < int'(MAX_BLOCKS)) &&
               ((int'(thr_cnt) + int'(req_threads)) <= int'(MAX_THREADS));
    end

    // Counters take admission and release in one combined update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt <= '0;
            thr_cnt <= '0;
        end else begin
            blk_cnt <= blk_cnt + CNT_W'(admit) - CNT_W'(release_en);
            thr_cnt <= thr_cnt
                     + (admit      ? RES_W'(req_threads)     : '0)
                     - (release_en ? RES_W'(release_threads) : '0);
        end
    end

endmodule

// File: rtl/adm_slot_table.sv
// Module adm_slot_table
// Tracks which residency slots hold a block and the size of each block.
// Assumes: alloc_en only when a free slot exists; a retire of a free slot is ignored.
module adm_slot_table #(
    parameter int unsigned NSLOTS = 8,
    parameter int unsigned SLOT_W = 3,
    parameter int unsigned REQ_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [REQ_W-1:0]  alloc_threads,
    input  logic              retire_valid,
    input  logic [SLOT_W-1:0] retire_slot,
    output logic [SLOT_W-1:0] free_slot,
    output logic              any_free,
    output logic              retire_hit,
    output logic [REQ_W-1:0]  retire_threads,
    output logic [NSLOTS-1:0] slot_busy
);

    logic [REQ_W-1:0] slot_thr [NSLOTS];

    // Pick the lowest-numbered free slot.
    always_comb begin
        free_slot = '0;
        any_free  = 1'b0;
        for (int i = int'(NSLOTS) - 1; i >= 0; i--) begin
            if (!slot_busy[i]) begin
                free_slot = SLOT_W'(i);
                any_free  = 1'b1;
            end
        end
    end

    // A retire counts only for an in-range slot that holds a block.
    always_comb begin
        retire_hit     = 1'b0;
        retire_threads = '0;
        if (int'(retire_slot) < int'(NSLOTS)) begin
            retire_hit     = retire_valid && slot_busy[retire_slot];
            retire_threads = slot_thr[retire_slot];
        end
    end

    for (genvar g = 0; g < NSLOTS; g++) begin : g_slot
        // Per-slot occupancy and block size.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_busy[g] <= 1'b0;
                slot_thr[g]  <= '0;
            end else if (alloc_en && free_slot == SLOT_W'(g)) begin
                slot_busy[g] <= 1'b1;
                slot_thr[g]  <= alloc_threads;
            end else if (retire_hit && retire_slot == SLOT_W'(g)) begin
                slot_busy[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adm_warp_split.sv
// Module adm_warp_split
// Issues one warp descriptor per cycle for a loaded block, from warp 0 upward.
// Assumes: load is only raised while not busy; WARP_LANES is a power of two.
module adm_warp_split
    import adm_pkg::*;
#(
    parameter int unsigned WARP_LANES = 32,
    parameter int unsigned REQ_W      = 11,
    parameter int unsigned SLOT_W     = 3,
    parameter int unsigned WID_W      = 5,
    parameter int unsigned TID_W      = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [SLOT_W-1:0]     load_slot,
    input  logic [REQ_W-1:0]      load_threads,
    output logic                  busy,
    output logic [SLOT_W-1:0]     w_slot,
    output logic [WID_W-1:0]      w_id,
    output logic [TID_W-1:0]      w_first,
    output logic [TID_W-1:0]      w_last,
    output logic [WARP_LANES-1:0] w_mask
);

    localparam int unsigned LANE_W = idx_bits(WARP_LANES);

    split_state_t      st;
    logic [SLOT_W-1:0] slot_q;
    logic [REQ_W-1:0]  thr_q;
    logic [WID_W-1:0]  wid_q;
    logic [WID_W-1:0]  wlast_q;
    logic [REQ_W-1:0]  first_n;
    logic [REQ_W-1:0]  rem_n;
    logic              full_w;

    // Walk the warps of the loaded block, one per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SPLIT_IDLE;
            slot_q  <= '0;
            thr_q   <= '0;
            wid_q   <= '0;
            wlast_q <= '0;
        end else begin
            case (st)
                SPLIT_IDLE: begin
                    if (load) begin
                        st      <= SPLIT_RUN;
                        slot_q  <= load_slot;
                        thr_q   <= load_threads;
                        wid_q   <= '0;
                        wlast_q <= WID_W'((load_threads - 1'b1) >> LANE_W);
                    end
                end
                default: begin
                    if (wid_q == wlast_q) begin
                        st <= SPLIT_IDLE;
                    end else begin
                        wid_q <= wid_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // Thread range and lane mask of the current warp.
    always_comb begin
        first_n = REQ_W'(wid_q) << LANE_W;
        rem_n   = thr_q - first_n;
        full_w  = rem_n >= REQ_W'(WARP_LANES);
        w_first = TID_W'(first_n);
        w_last  = full_w ? TID_W'(first_n + REQ_W'(WARP_LANES - 1))
                         : TID_W'(thr_q - 1'b1);
        w_mask  = full_w ? '1 : ~({WARP_LANES{1'b1}} << rem_n[LANE_W-1:0]);
    end

    assign busy   = (st == SPLIT_RUN);
    assign w_slot = slot_q;
    assign w_id   = wid_q;

endmodule

// File: rtl/block_admit_warp_split.sv
// Module block_admit_warp_split
// Admits thread blocks under block-count and thread-count limits, assigns a
// residency slot, and splits each admitted block into warps issued one per cycle.
// Assumes: req_threads is between 1 and MAX_BLOCK_THREADS while req_valid is high.
module block_admit_warp_split
    import adm_pkg::*;
#(
    parameter int unsigned MAX_BLOCKS        = 8,
    parameter int unsigned MAX_THREADS       = 1536,
    parameter int unsigned MAX_BLOCK_THREADS = 1024,
    parameter int unsigned WARP_LANES        = 32,
    localparam int unsigned SLOT_W = idx_bits(MAX_BLOCKS),
    localparam int unsigned REQ_W  = $clog2(MAX_BLOCK_THREADS + 1),
    localparam int unsigned RES_W  = $clog2(MAX_THREADS + 1),
    localparam int unsigned CNT_W  = $clog2(MAX_BLOCKS + 1),
    localparam int unsigned WARPS  = (MAX_BLOCK_THREADS + WARP_LANES - 1) / WARP_LANES,
    localparam int unsigned WID_W  = idx_bits(WARPS),
    localparam int unsigned TID_W  = idx_bits(MAX_BLOCK_THREADS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [REQ_W-1:0]      req_threads,
    output logic                  req_ready,
    input  logic                  retire_valid,
    input  logic [SLOT_W-1:0]     retire_slot,
    output logic                  warp_valid,
    output logic [SLOT_W-1:0]     warp_slot,
    output logic [WID_W-1:0]      warp_id,
    output logic [TID_W-1:0]      warp_first_tid,
    output logic [TID_W-1:0]      warp_last_tid,
    output logic [WARP_LANES-1:0] warp_lane_mask,
    output logic [CNT_W-1:0]      resident_blocks,
    output logic [RES_W-1:0]      resident_threads
);

    logic                  fits;
    logic                  any_free;
    logic                  accept;
    logic                  split_busy;
    logic                  retire_hit;
    logic [REQ_W-1:0]      retire_threads;
    logic [SLOT_W-1:0]     free_slot;
    logic [MAX_BLOCKS-1:0] slot_busy;

    // Ready needs room in both limits, a free slot and an idle splitter.
    assign req_ready = fits && any_free && !split_busy;
    assign accept    = req_valid && req_ready;

    adm_capacity #(
        .MAX_BLOCKS (MAX_BLOCKS),
        .MAX_THREADS(MAX_THREADS),
        .REQ_W      (REQ_W),
        .RES_W      (RES_W),
        .CNT_W      (CNT_W)
    ) u_cap (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_threads    (req_threads),
        .admit          (accept),
        .release_en     (retire_hit),
        .release_threads(retire_threads),
        .fits           (fits),
        .blk_cnt        (resident_blocks),
        .thr_cnt        (resident_threads)
    );

    adm_slot_table #(
        .NSLOTS(MAX_BLOCKS),
        .SLOT_W(SLOT_W),
        .REQ_W (REQ_W)
    ) u_slots (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_en      (accept),
        .alloc_threads (req_threads),
        .retire_valid  (retire_valid),
        .retire_slot   (retire_slot),
        .free_slot     (free_slot),
        .any_free      (any_free),
        .retire_hit    (retire_hit),
        .retire_threads(retire_threads),
        .slot_busy     (slot_busy)
    );

    adm_warp_split #(
        .WARP_LANES(WARP_LANES),
        .REQ_W     (REQ_W),
        .SLOT_W    (SLOT_W),
        .WID_W     (WID_W),
        .TID_W     (TID_W)
    ) u_split (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .load_slot   (free_slot),
        .load_threads(req_threads),
        .busy        (split_busy),
        .w_slot      (warp_slot),
        .w_id        (warp_id),
        .w_first     (warp_first_tid),
        .w_last      (warp_last_tid),
        .w_mask      (warp_lane_mask)
    );

    assign warp_valid = split_busy;

endmodule

// File: rtl/adm_checker.sv
// Module adm_checker
// Temporal properties of the admission and warp partitioner, bound to its top.
// Assumes: observes only; drives nothing.
module adm_checker #(
    parameter int unsigned MAX_BLOCKS  = 8,
    parameter int unsigned MAX_THREADS = 1536,
    parameter int unsigned WARP_LANES  = 32,
    parameter int unsigned SLOT_W      = 3,
    parameter int unsigned WID_W       = 5,
    parameter int unsigned TID_W       = 10,
    parameter int unsigned CNT_W       = 4,
    parameter int unsigned RES_W       = 11
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  retire_valid,
    input logic [SLOT_W-1:0]     retire_slot,
    input logic [MAX_BLOCKS-1:0] slot_busy,
    input logic                  warp_valid,
    input logic [WID_W-1:0]      warp_id,
    input logic [TID_W-1:0]      warp_first_tid,
    input logic [TID_W-1:0]      warp_last_tid,
    input logic [WARP_LANES-1:0] warp_lane_mask,
    input logic [CNT_W-1:0]      resident_blocks,
    input logic [RES_W-1:0]      resident_threads
);

    logic acc;
    logic hit;
    assign acc = req_valid && req_ready;
    assign hit = retire_valid && slot_busy[retire_slot];

    p_caps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(resident_blocks) <= int'(MAX_BLOCKS) &&
        int'(resident_threads) <= int'(MAX_THREADS));

    p_first_warp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> warp_valid && warp_id == '0);

    p_warp_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (warp_valid && $past(warp_valid) && warp_id != '0) |->
        warp_id == $past(warp_id) + 1'b1);

    p_tid_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid |-> (int'(warp_first_tid) == int'(warp_id) * int'(WARP_LANES)) &&
                       (warp_last_tid >= warp_first_tid) &&
                       (int'(warp_last_tid) - int'(warp_first_tid) < int'(WARP_LANES)));

    p_mask_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid |-> warp_lane_mask[0] &&
                       ((warp_lane_mask & (warp_lane_mask + 1'b1)) == '0) &&
                       ($countones(warp_lane_mask) ==
                        int'(warp_last_tid) - int'(warp_first_tid) + 1));

    p_no_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        warp_valid |-> !req_ready);

    p_retire_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !acc) |=> resident_blocks == $past(resident_blocks) - 1'b1);

    p_retire_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && !slot_busy[retire_slot] && !acc) |=>
        $stable(resident_blocks) && $stable(resident_threads));

    p_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && hit) |=> $stable(resident_blocks));

endmodule

bind block_admit_warp_split adm_checker #(
    .MAX_BLOCKS (MAX_BLOCKS),
    .MAX_THREADS(MAX_THREADS),
    .WARP_LANES (WARP_LANES),
    .SLOT_W     (SLOT_W),
    .WID_W      (WID_W),
    .TID_W      (TID_W),
    .CNT_W      (CNT_W),
    .RES_W      (RES_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .retire_valid    (retire_valid),
    .retire_slot     (retire_slot),
    .slot_busy       (slot_busy),
    .warp_valid      (warp_valid),
    .warp_id         (warp_id),
    .warp_first_tid  (warp_first_tid),
    .warp_last_tid   (warp_last_tid),
    .warp_lane_mask  (warp_lane_mask),
    .resident_blocks (resident_blocks),
    .resident_threads(resident_threads)
);

// File: tb/sim_block_admit_warp_split.sv
// Scoreboard bench: the driver predicts each warp at acceptance and queues it,
// and a monitor compares issued warps against the queue.
module sim_block_admit_warp_split;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [10:0] req_threads = 11'd1;
    logic        req_ready;
    logic        retire_valid = 1'b0;
    logic [2:0]  retire_slot = '0;
    logic        warp_valid;
    logic [2:0]  warp_slot;
    logic [4:0]  warp_id;
    logic [9:0]  warp_first_tid;
    logic [9:0]  warp_last_tid;
    logic [31:0] warp_lane_mask;
    logic [3:0]  resident_blocks;
    logic [10:0] resident_threads;

    typedef struct {
        int          slot;
        int          id;
        int          first;
        int          last;
        logic [31:0] mask;
    } exp_warp_t;

    exp_warp_t exp_q[$];
    int  checks = 0;
    int  errors = 0;
    bit  m_busy[8];
    int  m_thr[8];
    int  m_blocks = 0;
    int  m_threads = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    block_admit_warp_split u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_threads     (req_threads),
        .req_ready       (req_ready),
        .retire_valid    (retire_valid),
        .retire_slot     (retire_slot),
        .warp_valid      (warp_valid),
        .warp_slot       (warp_slot),
        .warp_id         (warp_id),
        .warp_first_tid  (warp_first_tid),
        .warp_last_tid   (warp_last_tid),
        .warp_lane_mask  (warp_lane_mask),
        .resident_blocks (resident_blocks),
        .resident_threads(resident_threads)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_counts(input string req);
        check(int'(resident_blocks) == m_blocks, req, "resident_blocks",
              resident_blocks, m_blocks);
        check(int'(resident_threads) == m_threads, req, "resident_threads",
              resident_threads, m_threads);
    endtask

    // Driver: hold the request until ready, then predict slot and warps.
    task automatic send_block(input int n);
        int s;
        @(negedge clk);
        req_valid   = 1'b1;
        req_threads = 11'(n);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        s = -1;
        for (int i = 7; i >= 0; i--) if (!m_busy[i]) s = i;
        m_busy[s] = 1'b1;
        m_thr[s]  = n;
        for (int k = 0; k < (n + 31) / 32; k++) begin
            exp_warp_t e;
            int rem;
            rem     = n - 32 * k;
            e.slot  = s;
            e.id    = k;
            e.first = 32 * k;
            e.last  = (rem >= 32) ? 32 * k + 31 : n - 1;
            e.mask  = (rem >= 32) ? 32'hFFFF_FFFF : ((32'h1 << rem) - 32'h1);
            exp_q.push_back(e);
        end
        @(posedge clk);
        m_blocks++;
        m_threads += n;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic retire(input int s);
        @(negedge clk);
        retire_valid = 1'b1;
        retire_slot  = 3'(s);
        @(posedge clk);
        if (m_busy[s]) begin
            m_busy[s] = 1'b0;
            m_blocks--;
            m_threads -= m_thr[s];
        end
        @(negedge clk);
        retire_valid = 1'b0;
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(negedge clk);
        @(negedge clk);
        #1;
    endtask

    // Monitor: compare every issued warp with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && warp_valid) begin
            check(req_ready == 1'b0, "R7", "ready while issuing", req_ready, 0);
            if (exp_q.size() == 0) begin
                check(1'b0, "R4", "unexpected warp id", warp_id, -1);
            end else begin
                exp_warp_t e;
                e = exp_q.pop_front();
                check(int'(warp_slot) == e.slot, "R3", "warp_slot", warp_slot, e.slot);
                check(int'(warp_id) == e.id, "R4", "warp_id", warp_id, e.id);
                check(int'(warp_first_tid) == e.first, "R5", "first tid",
                      warp_first_tid, e.first);
                check(int'(warp_last_tid) == e.last, "R5", "last tid",
                      warp_last_tid, e.last);
                check(warp_lane_mask == e.mask, "R6", "lane mask",
                      warp_lane_mask, e.mask);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        check(warp_valid == 1'b0, "R1", "warp_valid", warp_valid, 0);
        check_counts("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R4 R5 R6: full warps, partial warp, single-lane block
        send_block(256);
        drain();
        check_counts("R2");
        send_block(40);
        send_block(1);
        drain();
        check_counts("R2");

        // R8: retire a resident slot; R9: retire it again
        retire(1);
        #1;
        check_counts("R8");
        retire(1);
        #1;
        check_counts("R9");
        retire(6);
        #1;
        check_counts("R9");

        // R3: freed slot 1 is reused as the lowest free slot
        send_block(33);
        drain();

        // R10: acceptance and retirement at the same edge
        fork
            send_block(100);
            retire(0);
        join
        drain();
        check_counts("R10");
        for (int s = 0; s < 8; s++) retire(s);
        #1;
        check_counts("R8");

        // R2: thread limit reached with free slots left
        for (int b = 0; b < 6; b++) send_block(256);
        drain();
        check_counts("R2");
        fork
            send_block(1);
            begin
                repeat (5) @(negedge clk);
                #2;
                check(req_ready == 1'b0, "R2", "ready at thread limit", req_ready, 0);
                check_counts("R2");
                retire(3);
            end
        join
        drain();
        check_counts("R3");
        for (int s = 0; s < 8; s++) retire(s);

        // R11: only one 1024-thread block at a time
        send_block(1024);
        drain();
        fork
            send_block(1024);
            begin
                repeat (4) @(negedge clk);
                #2;
                check(req_ready == 1'b0, "R11", "second 1024 block", req_ready, 0);
                check_counts("R11");
                retire(0);
            end
        join
        drain();
        check_counts("R11");
        retire(0);

        // R11: block limit with 64-thread blocks
        for (int b = 0; b < 8; b++) send_block(64);
        drain();
        check_counts("R11");
        fork
            send_block(64);
            begin
                repeat (4) @(negedge clk);
                #2;
                check(req_ready == 1'b0, "R11", "ninth block", req_ready, 0);
                check(int'(resident_threads) == 512, "R11", "threads at block limit",
                      resident_threads, 512);
                retire(5);
            end
        join
        drain();
        check_counts("R2");
        for (int s = 0; s < 8; s++) retire(s);
        #1;
        check_counts("R8");
        check(exp_q.size() == 0, "R4", "warps left pending", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule